// File: doc/BRIEF.md
# Stereo Pseudo-Log Volume with Soft Ramp and Soft Mute

This block scales a two-channel, 24-bit playback stream by a gain chosen from a 7-bit volume code per channel. Each code maps to a linear gain between 0 and 8031 through a piecewise exponential curve. A code of 0 mutes the channel, and a code of 127 gives unity. The block never jumps to a new gain. On every sample strobe the internal gain moves by a single linear step toward the target, so a volume change cannot produce a click.

A soft-mute control sits after the volume stage, and the two stages multiply. When soft mute is raised, a linear factor falls from 1024 to 0 over 1024 sample strobes. When soft mute is dropped, the factor climbs back. A release partway through a ramp reverses it from the factor reached so far.

Dropping the `run` input, which models the playback path being powered down or held in reset, forces both gains to zero at once. When `run` returns, the gains fade back in from zero. Outputs are registered and change only on a sample strobe.

Top module: `stereo_vol_ramp`

## Requirements
- R1: A volume code c, with m = c[6:4] and l = c[3:0], selects the target gain ((2·l + 33) << m) − 33. Code 0 gives 0, code 1 gives 2, code 64 gives 495 and code 127 gives 8031. No gain ever exceeds 8031.
- R2: On each cycle with `frame_tick` high and `run` high, a channel's gain moves by exactly 1 toward its target, or stays put if it already equals the target. Without a strobe the gain holds.
- R3: The left and right channels each use their own code, gain and input. Neither channel affects the other.
- R4: While `run` is low, both gains are zero from the next clock edge onward. After `run` rises, each gain climbs from zero by one step per strobe.
- R5: The mute factor starts at 1024. It changes only on a strobe. It falls by 1 per strobe while `soft_mute` is high, down to 0, and rises by 1 per strobe while `soft_mute` is low, up to 1024. The mute state machine has four states: PASS (factor 1024), FALL, SILENT (factor 0) and RISE. Its transitions are PASS→FALL on mute, FALL→SILENT when the factor reaches 0, FALL→RISE (or →PASS at 1023) on release, SILENT→RISE on release, RISE→PASS when the factor reaches 1024, and RISE→FALL (or →SILENT at 1) on mute.
- R6: If `soft_mute` is released before the factor reaches 0, the factor climbs back from its current value without first completing the fall.
- R7: The volume and mute stages act in series. The output is v2 = round(v1·f/1024), where v1 = round(x·G/8031), G is the channel gain and f is the mute factor. When the factor is 0, the output is 0.
- R8: Each rounding is to the nearest integer of the magnitude, with the input's sign applied afterwards (half away from zero). The result is clipped to the range −8388608 to 8388607. With G = 2 and f = 1024, an input of 2008 gives 1, 2007 gives 0 and −2008 gives −1. With G = 8031, both full-scale extremes pass through unchanged.
- R9: On a strobe, each output takes the value computed from that strobe's input sample and from the gain and factor held just before the strobe. The outputs hold between strobes.
- R10: During reset, both outputs are 0, both gains are 0 and the mute factor is 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_tick | input | 1 | One-cycle sample strobe derived from the frame clock |
| run | input | 1 | Playback active; low forces both gains to zero |
| soft_mute | input | 1 | Soft-mute request |
| vol_l | input | 7 | Left volume code |
| vol_r | input | 7 | Right volume code |
| in_l | input | 24 | Left input sample, two's complement |
| in_r | input | 24 | Right input sample, two's complement |
| out_l | output | 24 | Left output sample, two's complement |
| out_r | output | 24 | Right output sample, two's complement |

## Verification
The assertions assume that `frame_tick` is a single-cycle pulse, and that `run`, `soft_mute` and the codes are synchronous to `clk`. They make no assumption about how far apart strobes are, or about the order in which codes change. The stimulus generates each strobe itself, three cycles apart. It changes `run` and the codes only between strobes, at least one clock edge before the next strobe, so the zeroing caused by `run` is settled before any sample is taken. Random codes, samples, `run` drops and mute toggles are drawn from a fixed seed. Around them, directed sequences walk every code, reverse a partial mute ramp and hit the rounding and clipping corners.

// File: rtl/svr_pkg.sv
package svr_pkg;

    typedef enum logic [1:0] {
        MS_PASS   = 2'd0,
        MS_FALL   = 2'd1,
        MS_SILENT = 2'd2,
        MS_RISE   = 2'd3
    } mute_state_t;

    // Linear gain for a volume code: upper bits give the exponent,
    // lower lw bits the mantissa.
    function automatic int lin_gain(input int code, input int lw);
        int m;
        int l;
        int ofs;
        m   = code >> lw;
        l   = code & ((1 << lw) - 1);
        ofs = (1 << (lw + 1)) + 1;
        return ((2 * l + ofs) << m) - ofs;
    endfunction

endpackage

// File: rtl/svr_gain_slew.sv
module svr_gain_slew
    import svr_pkg::*;
#(
    parameter int CW = 7,
    parameter int LW = 4,
    parameter int GW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic [CW-1:0] code,
    output logic [GW-1:0] gain
);

    logic [GW-1:0] target;

    always_comb begin
        target = GW'(lin_gain(int'(code), LW));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain <= '0;
        end else if (!run) begin
            gain <= '0;
        end else if (tick) begin
            if (gain < target) begin
                gain <= gain + 1'b1;
            end else if (gain > target) begin
                gain <= gain - 1'b1;
            end
        end
    end

endmodule

// File: rtl/svr_mute_ramp.sv
module svr_mute_ramp
    import svr_pkg::*;
#(
    parameter int RW = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        soft_mute,
    output logic [RW:0] factor
);

    localparam logic [RW:0] FULL    = (RW+1)'(1) << RW;
    localparam logic [RW:0] NEAR_UP = FULL - 1'b1;
    localparam logic [RW:0] ONE     = (RW+1)'(1);

    mute_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_PASS: begin
                if (soft_mute) state_d = MS_FALL;
            end
            MS_FALL: begin
                if (!soft_mute)          state_d = (factor == NEAR_UP) ? MS_PASS : MS_RISE;
                else if (factor == ONE)  state_d = MS_SILENT;
            end
            MS_SILENT: begin
                if (!soft_mute) state_d = MS_RISE;
            end
            MS_RISE: begin
                if (soft_mute)              state_d = (factor == ONE) ? MS_SILENT : MS_FALL;
                else if (factor == NEAR_UP) state_d = MS_PASS;
            end
            default: state_d = MS_PASS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MS_PASS;
        end else if (tick) begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            factor <= FULL;
        end else if (tick) begin
            unique case (state_d)
                MS_FALL, MS_SILENT: if (factor != '0)   factor <= factor - 1'b1;
                MS_PASS, MS_RISE:   if (factor != FULL) factor <= factor + 1'b1;
                default:            factor <= factor;
            endcase
        end
    end

endmodule

// File: rtl/svr_scale.sv
module svr_scale #(
    parameter int DW   = 24,
    parameter int GW   = 13,
    parameter int RW   = 10,
    parameter int GMAX = 8031
) (
    input  logic [DW-1:0] din,
    input  logic [GW-1:0] gain,
    input  logic [RW:0]   factor,
    output logic [DW-1:0] dout
);

    localparam int PW = DW + GW;
    localparam int QW = PW + RW + 1;
    localparam logic [QW-1:0] POS_MAX = QW'((longint'(1) << (DW - 1)) - 1);
    localparam logic [QW-1:0] NEG_MAX = QW'(longint'(1) << (DW - 1));

    logic          neg;
    logic [DW-1:0] mag;
    logic [PW-1:0] p1;
    logic [PW-1:0] q1;
    logic [QW-1:0] p2;
    logic [QW-1:0] q2;
    logic [QW-1:0] lim;

    always_comb begin
        neg = din[DW-1];
        mag = neg ? (~din + 1'b1) : din;
        p1  = PW'(mag) * PW'(gain);
        q1  = (p1 + PW'(GMAX / 2)) / PW'(GMAX);
        p2  = QW'(q1) * QW'(factor);
        q2  = (p2 + QW'(1 << (RW - 1))) >> RW;
        if (neg) lim = (q2 > NEG_MAX) ? NEG_MAX : q2;
        else     lim = (q2 > POS_MAX) ? POS_MAX : q2;
        dout = neg ? (~lim[DW-1:0] + 1'b1) : lim[DW-1:0];
    end

endmodule

// File: rtl/stereo_vol_ramp.sv
module stereo_vol_ramp
    import svr_pkg::*;
#(
    parameter int DW = 24,
    parameter int CW = 7,
    parameter int LW = 4,
    parameter int GW = 13,
    parameter int RW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_tick,
    input  logic          run,
    input  logic          soft_mute,
    input  logic [CW-1:0] vol_l,
    input  logic [CW-1:0] vol_r,
    input  logic [DW-1:0] in_l,
    input  logic [DW-1:0] in_r,
    output logic [DW-1:0] out_l,
    output logic [DW-1:0] out_r
);

    localparam int NCH  = 2;
    localparam int GMAX = lin_gain((1 << CW) - 1, LW);

    logic [NCH-1:0][CW-1:0] code_w;
    logic [NCH-1:0][DW-1:0] din_w;
    logic [NCH-1:0][DW-1:0] dout_w;
    logic [NCH-1:0][GW-1:0] gain_w;
    logic [RW:0]            mute_fac;

    assign code_w = {vol_r, vol_l};
    assign din_w  = {in_r, in_l};

    svr_mute_ramp #(.RW(RW)) u_mute (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (frame_tick),
        .soft_mute (soft_mute),
        .factor    (mute_fac)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        svr_gain_slew #(.CW(CW), .LW(LW), .GW(GW)) u_slew (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (frame_tick),
            .run   (run),
            .code  (code_w[ch]),
            .gain  (gain_w[ch])
        );

        svr_scale #(.DW(DW), .GW(GW), .RW(RW), .GMAX(GMAX)) u_scale (
            .din    (din_w[ch]),
            .gain   (gain_w[ch]),
            .factor (mute_fac),
            .dout   (dout_w[ch])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_l <= '0;
            out_r <= '0;
        end else if (frame_tick) begin
            out_l <= dout_w[0];
            out_r <= dout_w[1];
        end
    end

endmodule

// File: rtl/svr_checker.sv
module svr_checker #(
    parameter int DW   = 24,
    parameter int GW   = 13,
    parameter int RW   = 10,
    parameter int GMAX = 8031
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_tick,
    input logic               run,
    input logic [1:0][GW-1:0] gain,
    input logic [RW:0]        factor,
    input logic [DW-1:0]      out_l,
    input logic [DW-1:0]      out_r
);

    localparam logic [RW:0] FULL = (RW+1)'(1) << RW;

    AST_GAIN_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        gain[0] <= GW'(GMAX) && gain[1] <= GW'(GMAX)); // R1

    AST_STEP_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && run) |=> (gain[0] == $past(gain[0]) || gain[0] == $past(gain[0]) + 1'b1
                                 || gain[0] + 1'b1 == $past(gain[0]))); // R2

    AST_STEP_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && run) |=> (gain[1] == $past(gain[1]) || gain[1] == $past(gain[1]) + 1'b1
                                 || gain[1] + 1'b1 == $past(gain[1]))); // R2

    AST_GAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_tick && run) |=> $stable(gain)); // R2

    AST_RUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (gain == '0)); // R4

    AST_FACTOR_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        factor <= FULL); // R5

    AST_FACTOR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(factor)); // R5

    AST_SILENT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && factor == '0) |=> (out_l == '0 && out_r == '0)); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> ($stable(out_l) && $stable(out_r))); // R9

endmodule

bind stereo_vol_ramp svr_checker #(.DW(DW), .GW(GW), .RW(RW), .GMAX(GMAX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .run        (run),
    .gain       (gain_w),
    .factor     (mute_fac),
    .out_l      (out_l),
    .out_r      (out_r)
);

// File: tb/stereo_vol_ramp_test.sv
module stereo_vol_ramp_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_tick;
    logic        run;
    logic        soft_mute;
    logic [6:0]  vol_l, vol_r;
    logic [23:0] in_l, in_r;
    logic [23:0] out_l, out_r;

    int checks = 0;
    int errs   = 0;
    int mg[2];
    int mf;

    always #10 clk = ~clk;

    stereo_vol_ramp uut (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .run(run),
        .soft_mute(soft_mute), .vol_l(vol_l), .vol_r(vol_r),
        .in_l(in_l), .in_r(in_r), .out_l(out_l), .out_r(out_r)
    );

    function automatic int gain_of(input int c);
        int m = c / 16;
        int l = c % 16;
        return (2 * l + 33) * (1 << m) - 33;
    endfunction

    function automatic longint model_out(input longint x, input int g, input int f);
        longint mag = (x < 0) ? -x : x;
        longint q1  = (mag * g + 4015) / 8031;
        longint q2  = (q1 * f + 512) / 1024;
        longint r   = (x < 0) ? -q2 : q2;
        if (r > 8388607)  r = 8388607;
        if (r < -8388608) r = -8388608;
        return r;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input string req);
        longint e0, e1;
        int tg;
        @(negedge clk);
        if (!run) begin mg[0] = 0; mg[1] = 0; end
        e0 = model_out(longint'($signed(in_l)), mg[0], mf);
        e1 = model_out(longint'($signed(in_r)), mg[1], mf);
        frame_tick = 1'b1;
        if (run) begin
            for (int ch = 0; ch < 2; ch++) begin
                tg = gain_of(ch == 0 ? int'(vol_l) : int'(vol_r));
                if (mg[ch] < tg) mg[ch]++;
                else if (mg[ch] > tg) mg[ch]--;
            end
        end
        if (soft_mute) begin
            if (mf > 0) mf--;
        end else if (mf < 1024) mf++;
        @(negedge clk);
        frame_tick = 1'b0;
        chk(req, longint'($signed(out_l)), e0);
        chk(req, longint'($signed(out_r)), e1);
        @(negedge clk);
        chk("R9", longint'($signed(out_l)), e0);
        chk("R9", longint'($signed(out_r)), e1);
    endtask

    task automatic settle();
        while (mg[0] != gain_of(int'(vol_l)) || mg[1] != gain_of(int'(vol_r))) tick("R2");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        int seed = 32'h5A17;
        void'($urandom(seed));
        rst_n = 1'b0; frame_tick = 1'b0; run = 1'b0; soft_mute = 1'b0;
        vol_l = 7'd0; vol_r = 7'd1; in_l = 24'd8031; in_r = 24'd2008;
        mg[0] = 0; mg[1] = 0; mf = 1024;
        repeat (3) @(negedge clk);
        chk("R10", out_l, 0);
        chk("R10", out_r, 0);
        rst_n = 1'b1;
        run   = 1'b1;

        // R8 rounding with right gain 2
        settle();
        tick("R8");
        chk("R8", longint'($signed(out_r)), 1);
        in_r = 24'd2007;
        tick("R8");
        chk("R8", longint'($signed(out_r)), 0);
        in_r = -24'sd2008;
        tick("R8");
        chk("R8", longint'($signed(out_r)), -1);

        // R1 code walk on left, right busy with its own code (R3)
        vol_r = 7'd64;
        for (int c = 0; c < 128; c++) begin
            vol_l = 7'(c);
            in_r  = 24'($urandom);
            settle();
            tick("R1");
            chk("R1", longint'($signed(out_l)), gain_of(c));
        end
        in_r = 24'd8031;
        tick("R3");
        chk("R3", longint'($signed(out_l)), 8031);
        chk("R3", longint'($signed(out_r)), 495);

        // R8 clipping extremes at unity gain
        in_l = 24'h800000;
        tick("R8");
        chk("R8", longint'($signed(out_l)), -8388608);
        in_l = 24'h7FFFFF;
        tick("R8");
        chk("R8", longint'($signed(out_l)), 8388607);

        // R7 series: half mute factor
        vol_r = 7'd127;
        settle();
        in_l = 24'd1000;
        soft_mute = 1'b1;
        repeat (512) tick("R5");
        tick("R7");
        chk("R7", longint'($signed(out_l)), 500);
        // R6 reversal part-way
        soft_mute = 1'b0;
        repeat (300) tick("R6");
        soft_mute = 1'b1;
        repeat (100) tick("R6");
        soft_mute = 1'b0;
        repeat (400) tick("R6");
        chk("R6", mf, 1024);
        tick("R6");
        chk("R6", longint'($signed(out_l)), 1000);
        // R5 full fall and rise
        in_l = 24'd4000000; in_r = -24'sd3000000;
        soft_mute = 1'b1;
        repeat (1030) tick("R5");
        chk("R5", longint'($signed(out_l)), 0);
        chk("R5", longint'($signed(out_r)), 0);
        soft_mute = 1'b0;
        repeat (1030) tick("R5");
        chk("R5", longint'($signed(out_l)), 4000000);
        chk("R5", longint'($signed(out_r)), -3000000);

        // R4 run drop and fade-in
        in_l = 24'd8031;
        run = 1'b0;
        tick("R4");
        tick("R4");
        chk("R4", longint'($signed(out_l)), 0);
        run = 1'b1;
        repeat (5) tick("R4");
        chk("R4", longint'($signed(out_l)), 4);

        // Random mix
        for (int b = 0; b < 30; b++) begin
            vol_l     = 7'($urandom);
            vol_r     = 7'($urandom);
            soft_mute = ($urandom % 4) == 0;
            run       = ($urandom % 10) != 0;
            for (int k = 0; k < 150; k++) begin
                in_l = 24'($urandom);
                in_r = 24'($urandom);
                tick("R7");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

endmodule